// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is the register file and transfer fabric of a small accumulator machine. Six processor registers and a 16-bit word memory all hang off a single 16-bit bus. A 3-bit select input chooses which one source drives that bus in a given cycle. Any destination register whose load control is high captures the bus value on the next rising clock edge.

Each writable register also has its own increment and clear controls. The instruction register can only be loaded. The address register and the program counter are 12 bits wide. When either of them drives the bus, the upper bus bits read as zero. When either of them loads from the bus, it keeps only the low 12 bits.

The memory takes its address straight from the address register, never from the bus. It has separate read and write strobes. A write stores the present bus value at the current address on the clock edge.

A control sequencer outside this block drives the select and the per-register controls one cycle at a time. It uses the register outputs for its decisions.

Top module: `bus_xfer_datapath`

## Requirements
- R1: Select codes 1 to 6 place a register on the bus: 1 the 12-bit address register, 2 the 12-bit program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register. The two 12-bit sources appear with bus bits 15..12 at zero.
- R2: Select code 0 drives all zeros onto the bus.
- R3: Select code 7 with the read strobe high drives the memory word at the address held in the address register. Select code 7 with the read strobe low drives zeros.
- R4: A register with its load input high takes the bus value at the next rising edge. The address register and program counter take only bus bits 11..0.
- R5: A register with increment high, and load and clear low, adds one at the next edge. It wraps to zero past its all-ones value: 0xFFF for 12-bit registers, 0xFFFF for 16-bit ones.
- R6: Clear forces a register to zero at the next edge. When several controls of one register are high together, clear wins over load, and load wins over increment.
- R7: The instruction register changes only when its load input is high. It has no increment or clear control.
- R8: With the write strobe high, the bus value is stored at the address the address register holds before the edge. This holds even if that register is loaded in the same cycle.
- R9: While the active-low reset is asserted, every register reads zero.
- R10: A register with none of its controls high keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the registers |
| bus_sel | input | 3 | Bus source select |
| ar_ld | input | 1 | Address register load |
| ar_inc | input | 1 | Address register increment |
| ar_clr | input | 1 | Address register clear |
| pc_ld | input | 1 | Program counter load |
| pc_inc | input | 1 | Program counter increment |
| pc_clr | input | 1 | Program counter clear |
| dr_ld | input | 1 | Data register load |
| dr_inc | input | 1 | Data register increment |
| dr_clr | input | 1 | Data register clear |
| ac_ld | input | 1 | Accumulator load |
| ac_inc | input | 1 | Accumulator increment |
| ac_clr | input | 1 | Accumulator clear |
| tr_ld | input | 1 | Temporary register load |
| tr_inc | input | 1 | Temporary register increment |
| tr_clr | input | 1 | Temporary register clear |
| ir_ld | input | 1 | Instruction register load |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| bus_q | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
The bench builds the block with its default widths: a 16-bit bus and 12-bit addresses over a 4096-word memory. At these values a directed run of 4095 increments takes the program counter to 0xFFF and then wraps it. A 16-bit register counted up to 0x1000 puts a bit above the address field on the bus. Loading that value into the address register shows the truncation, and carrying it back onto the bus shows the zero extension. The random phase writes and reads back addresses across the whole 12-bit space, including loads of the address register in the same cycle as a write.

// File: rtl/bus_xfer_datapath.sv
module bus_xfer_datapath #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic              ar_ld,
  input  logic              ar_inc,
  input  logic              ar_clr,
  input  logic              pc_ld,
  input  logic              pc_inc,
  input  logic              pc_clr,
  input  logic              dr_ld,
  input  logic              dr_inc,
  input  logic              dr_clr,
  input  logic              ac_ld,
  input  logic              ac_inc,
  input  logic              ac_clr,
  input  logic              tr_ld,
  input  logic              tr_inc,
  input  logic              tr_clr,
  input  logic              ir_ld,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic [DATA_W-1:0] bus_q,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] dr_q,
  output logic [DATA_W-1:0] ac_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] tr_q
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD   = DATA_W - ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_word;
  logic [ADDR_W-1:0] bus_lo;

  assign rd_word = mem_rd ? mem[ar_q] : '0;
  assign bus_lo  = bus_q[ADDR_W-1:0];

  always_comb begin
    case (bus_sel)
      3'd1:    bus_q = {{PAD{1'b0}}, ar_q};
      3'd2:    bus_q = {{PAD{1'b0}}, pc_q};
      3'd3:    bus_q = dr_q;
      3'd4:    bus_q = ac_q;
      3'd5:    bus_q = ir_q;
      3'd6:    bus_q = tr_q;
      3'd7:    bus_q = rd_word;
      default: bus_q = '0;
    endcase
  end

  always_ff @(posedge clk)
    if (mem_wr) mem[ar_q] <= bus_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ar_q <= '0;
    else if (ar_clr) ar_q <= '0;
    else if (ar_ld)  ar_q <= bus_lo;
    else if (ar_inc) ar_q <= ar_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pc_q <= '0;
    else if (pc_clr) pc_q <= '0;
    else if (pc_ld)  pc_q <= bus_lo;
    else if (pc_inc) pc_q <= pc_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      dr_q <= '0;
    else if (dr_clr) dr_q <= '0;
    else if (dr_ld)  dr_q <= bus_q;
    else if (dr_inc) dr_q <= dr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ac_q <= '0;
    else if (ac_clr) ac_q <= '0;
    else if (ac_ld)  ac_q <= bus_q;
    else if (ac_inc) ac_q <= ac_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      tr_q <= '0;
    else if (tr_clr) tr_q <= '0;
    else if (tr_ld)  tr_q <= bus_q;
    else if (tr_inc) tr_q <= tr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ir_q <= '0;
    else if (ir_ld) ir_q <= bus_q;
endmodule

// File: rtl/bus_xfer_checker.sv
module bus_xfer_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  bus_sel,
  input logic              ar_ld,
  input logic              ar_clr,
  input logic              pc_ld,
  input logic              pc_inc,
  input logic              pc_clr,
  input logic              ac_ld,
  input logic              ac_clr,
  input logic              tr_ld,
  input logic              tr_inc,
  input logic              tr_clr,
  input logic              ir_ld,
  input logic [DATA_W-1:0] bus_q,
  input logic [ADDR_W-1:0] ar_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] ac_q,
  input logic [DATA_W-1:0] ir_q,
  input logic [DATA_W-1:0] tr_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R2
  sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd0 |-> bus_q == '0);

  // R1
  narrow_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 3'd1 || bus_sel == 3'd2) |-> bus_q[DATA_W-1:ADDR_W] == '0);

  // R6
  ac_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ac_clr |=> ac_q == '0);

  // R4
  ac_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ac_ld && !ac_clr |=> ac_q == $past(bus_q));

  // R4
  ar_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ar_ld && !ar_clr |=> ar_q == $past(bus_q[ADDR_W-1:0]));

  // R5
  tr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && tr_inc && !tr_ld && !tr_clr |=> tr_q == $past(tr_q) + 1'b1);

  // R7
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ir_ld |=> $stable(ir_q));

  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !pc_ld && !pc_inc && !pc_clr |=> $stable(pc_q));
endmodule

bind bus_xfer_datapath bus_xfer_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
  .ar_ld(ar_ld), .ar_clr(ar_clr),
  .pc_ld(pc_ld), .pc_inc(pc_inc), .pc_clr(pc_clr),
  .ac_ld(ac_ld), .ac_clr(ac_clr),
  .tr_ld(tr_ld), .tr_inc(tr_inc), .tr_clr(tr_clr),
  .ir_ld(ir_ld), .bus_q(bus_q), .ar_q(ar_q), .pc_q(pc_q),
  .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q)
);

// File: tb/bus_xfer_datapath_bench.sv
`timescale 1ns/1ps
module bus_xfer_datapath_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_sel = '0;
  logic ar_ld = 0, ar_inc = 0, ar_clr = 0, pc_ld = 0, pc_inc = 0, pc_clr = 0;
  logic dr_ld = 0, dr_inc = 0, dr_clr = 0, ac_ld = 0, ac_inc = 0, ac_clr = 0;
  logic tr_ld = 0, tr_inc = 0, tr_clr = 0, ir_ld = 0, mem_rd = 0, mem_wr = 0;
  logic [15:0] bus_q, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_ar, m_pc, m_dr, m_ac, m_ir, m_tr;
  logic [15:0] m_mem [4096];
  bit          m_ok  [4096];

  always #4 clk = ~clk;

  bus_xfer_datapath u_bus_xfer_datapath (
    .clk, .rst_n, .bus_sel,
    .ar_ld, .ar_inc, .ar_clr, .pc_ld, .pc_inc, .pc_clr,
    .dr_ld, .dr_inc, .dr_clr, .ac_ld, .ac_inc, .ac_clr,
    .tr_ld, .tr_inc, .tr_clr, .ir_ld, .mem_rd, .mem_wr,
    .bus_q, .ar_q, .pc_q, .dr_q, .ac_q, .ir_q, .tr_q
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] upd(input logic [15:0] q, input logic c, input logic l,
                                      input logic i, input logic [15:0] b, input logic [15:0] mask);
    if (c)      return 16'h0;
    else if (l) return b & mask;
    else if (i) return (q + 16'h1) & mask;
    else        return q;
  endfunction

  function automatic string tag_of(input logic c, input logic l, input logic i);
    if (c || (l && i)) return "R6";
    else if (l)        return "R4";
    else if (i)        return "R5";
    else               return "R10";
  endfunction

  function automatic logic [15:0] exp_bus();
    case (bus_sel)
      3'd1: return m_ar;
      3'd2: return m_pc;
      3'd3: return m_dr;
      3'd4: return m_ac;
      3'd5: return m_ir;
      3'd6: return m_tr;
      3'd7: return mem_rd ? m_mem[m_ar[11:0]] : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic cycle();
    logic [15:0] b;
    b = exp_bus();
    #1;
    if (bus_sel == 3'd0)      check("R2", bus_q, b);
    else if (bus_sel != 3'd7) check("R1", bus_q, b);
    else if (!mem_rd)         check("R3", bus_q, b);
    else if (m_ok[m_ar[11:0]]) check("R3/R8 read", bus_q, b);
    if (bus_sel == 3'd7 && mem_rd && !m_ok[m_ar[11:0]]) b = bus_q;
    if (mem_wr) begin
      m_mem[m_ar[11:0]] = b;
      m_ok[m_ar[11:0]]  = 1'b1;
    end
    m_ar = upd(m_ar, ar_clr, ar_ld, ar_inc, b, 16'h0FFF);
    m_pc = upd(m_pc, pc_clr, pc_ld, pc_inc, b, 16'h0FFF);
    m_dr = upd(m_dr, dr_clr, dr_ld, dr_inc, b, 16'hFFFF);
    m_ac = upd(m_ac, ac_clr, ac_ld, ac_inc, b, 16'hFFFF);
    m_tr = upd(m_tr, tr_clr, tr_ld, tr_inc, b, 16'hFFFF);
    m_ir = upd(m_ir, 1'b0, ir_ld, 1'b0, b, 16'hFFFF);
    @(posedge clk);
    #1;
    check({tag_of(ar_clr, ar_ld, ar_inc), " ar"}, {4'h0, ar_q}, m_ar);
    check({tag_of(pc_clr, pc_ld, pc_inc), " pc"}, {4'h0, pc_q}, m_pc);
    check({tag_of(dr_clr, dr_ld, dr_inc), " dr"}, dr_q, m_dr);
    check({tag_of(ac_clr, ac_ld, ac_inc), " ac"}, ac_q, m_ac);
    check({tag_of(tr_clr, tr_ld, tr_inc), " tr"}, tr_q, m_tr);
    check(ir_ld ? "R4 ir" : "R7 ir", ir_q, m_ir);
    @(negedge clk);
  endtask

  task automatic idle();
    {ar_ld, ar_inc, ar_clr, pc_ld, pc_inc, pc_clr, dr_ld, dr_inc, dr_clr} = '0;
    {ac_ld, ac_inc, ac_clr, tr_ld, tr_inc, tr_clr, ir_ld, mem_rd, mem_wr} = '0;
    bus_sel = 3'd0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4096; k++) m_ok[k] = 1'b0;
    {m_ar, m_pc, m_dr, m_ac, m_ir, m_tr} = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 ar", {4'h0, ar_q}, 16'h0);
    check("R9 pc", {4'h0, pc_q}, 16'h0);
    check("R9 ac", ac_q, 16'h0);
    check("R9 ir", ir_q, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 program counter wrap at 0xFFF
    idle(); pc_inc = 1;
    for (int k = 0; k < 4095; k++) cycle();
    check("R5 pc top", {4'h0, pc_q}, 16'h0FFF);
    idle(); bus_sel = 3'd2; ar_ld = 1; cycle();
    check("R4 ar from pc", {4'h0, ar_q}, 16'h0FFF);
    idle(); pc_inc = 1; cycle();
    check("R5 pc wrap", {4'h0, pc_q}, 16'h0000);

    // R1/R4 truncation and zero extension
    idle(); tr_inc = 1;
    for (int k = 0; k < 4097; k++) cycle();
    idle(); bus_sel = 3'd6; ar_ld = 1; ac_ld = 1; cycle();
    check("R4 ar trunc", {4'h0, ar_q}, 16'h0001);
    check("R4 ac full", ac_q, 16'h1001);
    idle(); bus_sel = 3'd1; cycle();

    // R6 priority
    idle(); bus_sel = 3'd4; ac_clr = 1; ac_ld = 1; ac_inc = 1; dr_ld = 1; dr_inc = 1; cycle();
    check("R6 clr wins", ac_q, 16'h0);
    check("R6 ld wins", dr_q, 16'h1001);

    // R8 write with address loaded in the same edge
    idle(); bus_sel = 3'd3; mem_wr = 1; ar_ld = 1; cycle();
    idle(); bus_sel = 3'd6; ar_clr = 1; cycle();
    idle(); ar_inc = 1; cycle();
    idle(); bus_sel = 3'd7; mem_rd = 1; cycle();
    idle(); bus_sel = 3'd7; mem_rd = 0; cycle();

    // random phase
    for (int n = 0; n < 6000; n++) begin
      bus_sel = 3'($urandom_range(0, 7));
      ar_clr = ($urandom_range(0, 9) == 0); ar_ld = ($urandom_range(0, 2) == 0); ar_inc = $urandom_range(0, 1);
      pc_clr = ($urandom_range(0, 9) == 0); pc_ld = ($urandom_range(0, 2) == 0); pc_inc = $urandom_range(0, 1);
      dr_clr = ($urandom_range(0, 9) == 0); dr_ld = ($urandom_range(0, 2) == 0); dr_inc = $urandom_range(0, 1);
      ac_clr = ($urandom_range(0, 9) == 0); ac_ld = ($urandom_range(0, 2) == 0); ac_inc = $urandom_range(0, 1);
      tr_clr = ($urandom_range(0, 9) == 0); tr_ld = ($urandom_range(0, 2) == 0); tr_inc = $urandom_range(0, 1);
      ir_ld = ($urandom_range(0, 2) == 0);
      mem_rd = ($urandom_range(0, 3) != 0);
      mem_wr = $urandom_range(0, 1);
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule